// File: doc/BRIEF.md
# Flash Status and Write-Protection Controller

This block owns the status byte of a serial flash device and rules on every command frame that the serial front end has finished receiving. At the end of each frame (chip-select rising) the front end presents the opcode, the 24-bit target address, the number of serial clocks counted in the frame, and the data byte for a status write. In the same cycle the block answers with exactly one of two pulses, accept or ignore. It then updates the write-enable latch, the protection bits, the single unlocked sector and the busy countdown.

Program, erase and status-write commands run for a parameterised number of cycles. The block exposes the remaining count and shows the write-in-progress flag in the status byte. A write is refused for any of these reasons: the write-enable latch is clear, the frame length is wrong, the target lies inside the block-protected region, the status register is locked by the protect-lock bit together with a low write-protect pin, or the device is busy. One 4 KB sector can be unlocked so that it escapes block protection.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte is 00h. Its layout is bit0 WIP, bit1 WEL, bits 4:2 protect level PL2:PL0, bit7 protect-lock (SRWD), and bits 6:5 always read 0.
- R2: Opcode 06h sets WEL and opcode 04h clears it. Both are accepted whenever the device is idle.
- R3: Status write (01h), program (02h), sector erase (20h, D7h), block erase (D8h) and chip erase (C7h, 60h) are ignored while WEL=0.
- R4: Frame length is checked exactly. A status write needs 16 clocks. A program needs at least 40 clocks and a multiple of 8. Sector and block erase need exactly 32 clocks. Chip erase needs exactly 8 clocks. Any other length is ignored.
- R5: A status write is ignored when SRWD=1 and wp_n=0. Otherwise it loads bit7 and bits 4:2 from cmd_wdata.
- R6: With ADDR_W=17 and address bits above ADDR_W ignored, PL1:PL0 select the protected range: 00 none, 01 the top quarter (018000h–01FFFFh), 10 the top half (010000h–01FFFFh), 11 everything. A program or erase aimed into that range is ignored.
- R7: Chip erase is ignored unless PL2:PL0 are all 0.
- R8: An accepted status write, program or erase sets WIP and loads busy_left with that class's cycle count. busy_left then counts down by one per cycle. WIP is held for exactly that many cycles, and WIP and WEL clear together when the count expires.
- R9: While WIP=1, every opcode except read status (05h) is ignored.
- R10: Sector unlock (26h) is accepted only with WEL=1, exactly 32 clocks and address bits 11:0 all zero, and it clears WEL. A program or sector erase inside the unlocked sector then bypasses block protection.
- R11: A 26h while a sector is already unlocked is ignored and leaves that sector unlocked. Sector lock (24h, clock count a multiple of 8) revokes the unlock.
- R12: For every cmd_valid, exactly one of cmd_accept and cmd_ignore pulses in the same cycle, and neither pulses without cmd_valid. Unlisted opcodes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle pulse: a frame has ended |
| cmd_op | input | 8 | Opcode of the frame |
| cmd_addr | input | 24 | Target address from the frame |
| cmd_clks | input | 16 | Serial clocks counted in the frame |
| cmd_wdata | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_accept | output | 1 | Frame accepted (same cycle as cmd_valid) |
| cmd_ignore | output | 1 | Frame ignored (same cycle as cmd_valid) |
| status_byte | output | 8 | Status byte for read status |
| busy_left | output | CNT_W | Cycles remaining in the busy window |

## Verification
Acceptance is driven from a table that pairs a write-enable state with an opcode, a clock count and an address. The patterns fall on both sides of each boundary of the top-quarter protected range, which separates address decoding from frame-length and latch checks. Directed sequences vary the lock bit against the pin level, the busy window cycle by cycle, the sector unlock with aligned, misaligned, duplicate and revoked requests, and chip erase with zero and non-zero protect levels. Taken together they show which individual condition causes each ignore.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SE_A  = 8'h20;
  localparam logic [7:0] OP_SE_B  = 8'hD7;
  localparam logic [7:0] OP_BE    = 8'hD8;
  localparam logic [7:0] OP_CE_A  = 8'hC7;
  localparam logic [7:0] OP_CE_B  = 8'h60;
  localparam logic [7:0] OP_UNL   = 8'h26;
  localparam logic [7:0] OP_LOCK  = 8'h24;

  localparam logic [15:0] CLK_WRSR  = 16'd16;
  localparam logic [15:0] CLK_PROG  = 16'd40;
  localparam logic [15:0] CLK_ERASE = 16'd32;
  localparam logic [15:0] CLK_CHIP  = 16'd8;
  localparam logic [15:0] CLK_UNL   = 16'd32;
endpackage

// File: rtl/flash_wp_range.sv
module flash_wp_range #(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 12
) (
  input  logic [1:0]               lvl,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     unl_vld,
  input  logic [ADDR_W-SECT_W-1:0] unl_sec,
  input  logic                     ovr_en,
  output logic                     hit
);
  logic in_range;
  logic bypass;

  always_comb begin
    unique case (lvl)
      2'b00:   in_range = 1'b0;
      2'b01:   in_range = &addr[ADDR_W-1 -: 2];
      2'b10:   in_range = addr[ADDR_W-1];
      default: in_range = 1'b1;
    endcase
  end

  assign bypass = ovr_en & unl_vld & (addr[ADDR_W-1:SECT_W] == unl_sec);
  assign hit    = in_range & ~bypass;
endmodule

// File: rtl/flash_wp_timer.sv
module flash_wp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] left
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));
  assign left = cnt_q;
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int SECT_W   = 12,
  parameter int WRSR_CYC = 10,
  parameter int PROG_CYC = 20,
  parameter int SE_CYC   = 40,
  parameter int BE_CYC   = 60,
  parameter int CE_CYC   = 80,
  localparam int MAX_CYC = (CE_CYC > BE_CYC) ? CE_CYC : BE_CYC,
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [23:0]      cmd_addr,
  input  logic [15:0]      cmd_clks,
  input  logic [7:0]       cmd_wdata,
  input  logic             wp_n,
  output logic             cmd_accept,
  output logic             cmd_ignore,
  output logic [7:0]       status_byte,
  output logic [CNT_W-1:0] busy_left
);
  localparam int SIDX_W = ADDR_W - SECT_W;

  logic              srwd_q, srwd_d;
  logic [2:0]        lvl_q, lvl_d;
  logic              wel_q, wel_d;
  logic              unl_vld_q, unl_vld_d;
  logic [SIDX_W-1:0] unl_sec_q, unl_sec_d;
  logic              reg_en;

  logic is_wren, is_wrdi, is_rdsr, is_wrsr, is_prog, is_se, is_be, is_ce;
  logic is_unl, is_lock, len8, ok, prot_hit, wip, t_done, t_load;
  logic [CNT_W-1:0] t_val;
  logic [ADDR_W-1:0] taddr;

  assign taddr   = cmd_addr[ADDR_W-1:0];
  assign is_wren = (cmd_op == OP_WREN);
  assign is_wrdi = (cmd_op == OP_WRDI);
  assign is_rdsr = (cmd_op == OP_RDSR);
  assign is_wrsr = (cmd_op == OP_WRSR);
  assign is_prog = (cmd_op == OP_PROG);
  assign is_se   = (cmd_op == OP_SE_A) | (cmd_op == OP_SE_B);
  assign is_be   = (cmd_op == OP_BE);
  assign is_ce   = (cmd_op == OP_CE_A) | (cmd_op == OP_CE_B);
  assign is_unl  = (cmd_op == OP_UNL);
  assign is_lock = (cmd_op == OP_LOCK);
  assign len8    = (cmd_clks[2:0] == 3'b000);

  flash_wp_range #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_range (
    .lvl     (lvl_q[1:0]),
    .addr    (taddr),
    .unl_vld (unl_vld_q),
    .unl_sec (unl_sec_q),
    .ovr_en  (is_prog | is_se),
    .hit     (prot_hit)
  );

  // acceptance decision
  always_comb begin
    ok = 1'b0;
    if (is_rdsr)                 ok = 1'b1;
    else if (wip)                ok = 1'b0;
    else if (is_wren | is_wrdi)  ok = 1'b1;
    else if (is_lock)            ok = len8;
    else if (is_unl)             ok = wel_q & (cmd_clks == CLK_UNL) &
                                      (taddr[SECT_W-1:0] == '0) & ~unl_vld_q;
    else if (is_wrsr)            ok = wel_q & (cmd_clks == CLK_WRSR) &
                                      ~(srwd_q & ~wp_n);
    else if (is_prog)            ok = wel_q & len8 & (cmd_clks >= CLK_PROG) &
                                      ~prot_hit;
    else if (is_se | is_be)      ok = wel_q & (cmd_clks == CLK_ERASE) &
                                      ~prot_hit;
    else if (is_ce)              ok = wel_q & (cmd_clks == CLK_CHIP) &
                                      (lvl_q == 3'b000);
  end

  assign cmd_accept = cmd_valid & ok;
  assign cmd_ignore = cmd_valid & ~ok;

  // busy window
  assign t_load = cmd_accept & (is_wrsr | is_prog | is_se | is_be | is_ce);

  always_comb begin
    t_val = CNT_W'(CE_CYC);
    if (is_wrsr)      t_val = CNT_W'(WRSR_CYC);
    else if (is_prog) t_val = CNT_W'(PROG_CYC);
    else if (is_se)   t_val = CNT_W'(SE_CYC);
    else if (is_be)   t_val = CNT_W'(BE_CYC);
  end

  flash_wp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .busy     (wip),
    .done     (t_done),
    .left     (busy_left)
  );

  // next state of status and unlock registers
  always_comb begin
    srwd_d    = srwd_q;
    lvl_d     = lvl_q;
    wel_d     = wel_q;
    unl_vld_d = unl_vld_q;
    unl_sec_d = unl_sec_q;
    if (t_done) wel_d = 1'b0;
    if (cmd_accept) begin
      if (is_wren) wel_d = 1'b1;
      if (is_wrdi) wel_d = 1'b0;
      if (is_wrsr) begin
        srwd_d = cmd_wdata[7];
        lvl_d  = cmd_wdata[4:2];
      end
      if (is_unl) begin
        unl_vld_d = 1'b1;
        unl_sec_d = taddr[ADDR_W-1:SECT_W];
        wel_d     = 1'b0;
      end
      if (is_lock) unl_vld_d = 1'b0;
    end
  end

  assign reg_en = cmd_accept | t_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd_q    <= 1'b0;
      lvl_q     <= 3'b000;
      wel_q     <= 1'b0;
      unl_vld_q <= 1'b0;
      unl_sec_q <= '0;
    end else if (reg_en) begin
      srwd_q    <= srwd_d;
      lvl_q     <= lvl_d;
      wel_q     <= wel_d;
      unl_vld_q <= unl_vld_d;
      unl_sec_q <= unl_sec_d;
    end
  end

  assign status_byte = {srwd_q, 2'b00, lvl_q, wel_q, wip};
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk
  import flash_wp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [7:0]       cmd_op,
  input logic [15:0]      cmd_clks,
  input logic             wp_n,
  input logic             cmd_accept,
  input logic             cmd_ignore,
  input logic [7:0]       status_byte,
  input logic [CNT_W-1:0] busy_left
);
  logic wr_class, timed_class;
  assign wr_class = (cmd_op == OP_WRSR) | (cmd_op == OP_PROG) | (cmd_op == OP_SE_A) |
                    (cmd_op == OP_SE_B) | (cmd_op == OP_BE) | (cmd_op == OP_CE_A) |
                    (cmd_op == OP_CE_B);
  assign timed_class = wr_class;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:5] == 2'b00); // R1
  AST_NEED_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wr_class && !status_byte[1] |-> !cmd_accept); // R3
  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_PROG) && (cmd_clks[2:0] != 3'b000) |-> !cmd_accept); // R4
  AST_SR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_WRSR) && status_byte[7] && !wp_n |-> !cmd_accept); // R5
  AST_CHIP_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && ((cmd_op == OP_CE_A) || (cmd_op == OP_CE_B)) && (status_byte[4:2] != 3'b000)
    |-> !cmd_accept); // R7
  AST_WIP_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && timed_class |=> status_byte[0]); // R8
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] && (busy_left > CNT_W'(1)) && !cmd_accept
    |=> busy_left == $past(busy_left) - CNT_W'(1)); // R8
  AST_DONE_CLR_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_byte[0]) |-> !status_byte[1]); // R8
  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && status_byte[0] && (cmd_op != OP_RDSR) |-> !cmd_accept); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones({cmd_accept, cmd_ignore}) == 1); // R12
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !cmd_accept && !cmd_ignore); // R12
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_clks    (cmd_clks),
  .wp_n        (wp_n),
  .cmd_accept  (cmd_accept),
  .cmd_ignore  (cmd_ignore),
  .status_byte (status_byte),
  .busy_left   (busy_left)
);

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;
  localparam int WRSR_CYC = 4;
  localparam int PROG_CYC = 5;
  localparam int SE_CYC   = 6;
  localparam int BE_CYC   = 7;
  localparam int CE_CYC   = 8;
  localparam int CNT_W    = $clog2(CE_CYC + 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [23:0] cmd_addr = 24'h0;
  logic [15:0] cmd_clks = 16'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic wp_n = 1'b1;
  logic cmd_accept, cmd_ignore;
  logic [7:0] status_byte;
  logic [CNT_W-1:0] busy_left;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic acc_s, ign_s;

  always #5 clk = ~clk;

  flash_wp_ctrl #(
    .WRSR_CYC(WRSR_CYC), .PROG_CYC(PROG_CYC), .SE_CYC(SE_CYC),
    .BE_CYC(BE_CYC), .CE_CYC(CE_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_clks(cmd_clks), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .cmd_accept(cmd_accept), .cmd_ignore(cmd_ignore),
    .status_byte(status_byte), .busy_left(busy_left)
  );

  // {set_wel, opcode, clocks, address, expect_accept}; protect level is 001 (top quarter)
  localparam logic [49:0] VEC [12] = '{
    {1'b1, 8'h02, 16'd40,   24'h000100, 1'b1},  // R6 below range
    {1'b1, 8'h02, 16'd40,   24'h018000, 1'b0},  // R6 first protected byte
    {1'b1, 8'h02, 16'd44,   24'h000100, 1'b0},  // R4 not a multiple of 8
    {1'b0, 8'h02, 16'd40,   24'h000100, 1'b0},  // R3 latch clear
    {1'b1, 8'h20, 16'd32,   24'h010000, 1'b1},  // R6 half boundary open at level 01
    {1'b1, 8'hD7, 16'd32,   24'h01F000, 1'b0},  // R6 protected sector
    {1'b1, 8'hD8, 16'd32,   24'h018000, 1'b0},  // R6 protected block
    {1'b1, 8'hD8, 16'd32,   24'h008000, 1'b1},  // R6 open block
    {1'b1, 8'h20, 16'd40,   24'h001000, 1'b0},  // R4 erase length exact
    {1'b1, 8'hC7, 16'd8,    24'h000000, 1'b0},  // R7 level non-zero
    {1'b1, 8'h02, 16'd2080, 24'h000000, 1'b1},  // R4 full page frame
    {1'b1, 8'h02, 16'd40,   24'h038000, 1'b0}   // R6 upper bits ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [15:0] clks,
                       input logic [23:0] addr, input logic [7:0] wd);
    @(negedge clk);
    cmd_op = op; cmd_clks = clks; cmd_addr = addr; cmd_wdata = wd;
    cmd_valid = 1'b1;
    #1;
    acc_s = cmd_accept;
    ign_s = cmd_ignore;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && status_byte[0]; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset status", {24'h0, status_byte}, 32'h00);
    chk("R1 reset busy_left", 32'(busy_left), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(8'h06, 16'd8, 24'h0, 8'h00);
    chk("R2 wren accept", {30'b0, acc_s, ign_s}, 32'b10);
    chk("R2 wel set", 32'(status_byte[1]), 32'd1);
    issue(8'h04, 16'd8, 24'h0, 8'h00);
    chk("R2 wel cleared", {24'h0, status_byte}, 32'h00);

    issue(8'h01, 16'd16, 24'h0, 8'hFF);
    chk("R3 wrsr without wel", {30'b0, acc_s, ign_s}, 32'b01);

    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'h01, 16'd24, 24'h0, 8'hFF);
    chk("R4 wrsr wrong length", 32'(acc_s), 32'd0);

    issue(8'h01, 16'd16, 24'h0, 8'hFF);
    chk("R5 wrsr accepted", 32'(acc_s), 32'd1);
    chk("R8 busy status", {24'h0, status_byte}, 32'h9F);
    chk("R8 busy_left load", 32'(busy_left), WRSR_CYC);
    repeat (WRSR_CYC - 1) @(negedge clk);
    chk("R8 last busy cycle", {24'h0, status_byte[1:0], 6'(busy_left)}, {24'h0, 2'b11, 6'd1});
    @(negedge clk);
    chk("R8 window end clears WIP and WEL", {24'h0, status_byte}, 32'h9C);

    wp_n = 1'b0;
    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'h01, 16'd16, 24'h0, 8'h00);
    chk("R5 locked write ignored", {30'b0, acc_s, ign_s}, 32'b01);
    chk("R5 status unchanged", {24'h0, status_byte}, 32'h9E);
    wp_n = 1'b1;
    issue(8'h01, 16'd16, 24'h0, 8'h04);
    chk("R5 pin high unlocks", 32'(acc_s), 32'd1);
    wait_idle();
    chk("R5 new status", {24'h0, status_byte}, 32'h04);

    for (int v = 0; v < 12; v++) begin
      if (VEC[v][49]) issue(8'h06, 16'd8, 24'h0, 8'h00);
      else            issue(8'h04, 16'd8, 24'h0, 8'h00);
      issue(VEC[v][48:41], VEC[v][40:25], VEC[v][24:1], 8'h00);
      chk($sformatf("R6 table entry %0d", v), {30'b0, acc_s, ign_s},
          VEC[v][0] ? 32'b10 : 32'b01);
      if (VEC[v][0]) chk($sformatf("R8 table entry %0d busy", v), 32'(status_byte[0]), 32'd1);
      wait_idle();
    end

    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'h02, 16'd40, 24'h000200, 8'h00);
    issue(8'h06, 16'd8, 24'h0, 8'h00);
    chk("R9 wren ignored while busy", {30'b0, acc_s, ign_s}, 32'b01);
    issue(8'h05, 16'd16, 24'h0, 8'h00);
    chk("R9 read status accepted while busy", 32'(acc_s), 32'd1);
    wait_idle();
    chk("R9 wel still clear", 32'(status_byte[1]), 32'd0);

    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'h26, 16'd32, 24'h018000, 8'h00);
    chk("R10 unlock accepted", 32'(acc_s), 32'd1);
    chk("R10 unlock clears wel", 32'(status_byte[1]), 32'd0);
    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'h02, 16'd40, 24'h018010, 8'h00);
    chk("R10 program in unlocked sector", 32'(acc_s), 32'd1);
    wait_idle();
    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'h02, 16'd40, 24'h019000, 8'h00);
    chk("R10 other sector stays protected", 32'(acc_s), 32'd0);
    issue(8'h26, 16'd32, 24'h01A000, 8'h00);
    chk("R11 second unlock ignored", 32'(acc_s), 32'd0);
    issue(8'h02, 16'd40, 24'h018000, 8'h00);
    chk("R11 first sector kept", 32'(acc_s), 32'd1);
    wait_idle();
    issue(8'h24, 16'd8, 24'h0, 8'h00);
    chk("R11 lock accepted", 32'(acc_s), 32'd1);
    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'h02, 16'd40, 24'h018000, 8'h00);
    chk("R11 lock revokes bypass", 32'(acc_s), 32'd0);
    issue(8'h26, 16'd32, 24'h018100, 8'h00);
    chk("R10 misaligned unlock ignored", 32'(acc_s), 32'd0);
    issue(8'h26, 16'd40, 24'h018000, 8'h00);
    chk("R10 unlock length ignored", 32'(acc_s), 32'd0);
    issue(8'h02, 16'd40, 24'h018000, 8'h00);
    chk("R10 still protected after rejects", 32'(acc_s), 32'd0);

    issue(8'h01, 16'd16, 24'h0, 8'h00);
    wait_idle();
    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'hC7, 16'd8, 24'h0, 8'h00);
    chk("R7 chip erase with level 0", 32'(acc_s), 32'd1);
    chk("R8 chip erase window", 32'(busy_left), CE_CYC);
    wait_idle();
    issue(8'h06, 16'd8, 24'h0, 8'h00);
    issue(8'h60, 16'd16, 24'h0, 8'h00);
    chk("R4 chip erase length", 32'(acc_s), 32'd0);
    issue(8'h60, 16'd8, 24'h0, 8'h00);
    chk("R7 alternate chip erase", 32'(acc_s), 32'd1);
    wait_idle();
    issue(8'h03, 16'd32, 24'h0, 8'h00);
    chk("R12 unknown opcode", {30'b0, acc_s, ign_s}, 32'b01);
    #1;
    chk("R12 no pulse when idle", {30'b0, cmd_accept, cmd_ignore}, 32'b00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule